// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block finds the single interrupt that a processor core should take next. It looks at two sources. The first is a bank of private interrupts, whose enable, pending, active, group and priority state arrive as input vectors. The second is a window of message-based interrupts held inside the block: a pending bitmap organised as bytes, and a configuration RAM with one byte per interrupt. Each of these interrupts carries an enable flag and a coarse priority field.

A scan starts on a one-cycle `start_i` pulse. It walks the private interrupts and then the message-based window, one entry per clock, and keeps the best candidate found so far. When the last entry has been compared, the block updates its registered result (valid flag, interrupt ID, priority) and pulses `done_o` for one cycle. Set and clear commands update the pending bitmap at any time. Commands that fall outside the window, or above a limit derived from a run-time ID-width input, are dropped. Configuration bytes are written through a simple write port.

Top module: `hppi_select`

## Requirements
- R1: A private interrupt p is a candidate only when its pending and enable bits are 1, its active bit is 0, and `grp_en_i[irq_grp_i[p]]` is 1. Its ID is p and its priority is byte p of `irq_prio_i`.
- R2: A candidate beats the current best when its priority value is numerically lower. When the priorities are equal, the lower ID wins. This holds across both sources.
- R3: Message interrupt j has ID `LPI_BASE + j`. It is a candidate only when its pending bit is 1, bit 0 of its configuration byte is 1, and `grp_en_i[1]` is 1. These interrupts always belong to group 1.
- R4: The priority of a message interrupt is bits 7:2 of its configuration byte, shifted left by two, so bits 1:0 of the priority are zero.
- R5: A set command writes 1 and a clear command writes 0 to bit (id % 8) of pending byte (id − LPI_BASE) / 8. Repeating a command leaves the state unchanged.
- R6: A command is ignored when its ID exceeds 1 << (`lpi_idbits_i` + 1), or when its ID lies outside [LPI_BASE, LPI_BASE + NUM_LPI).
- R7: A scan accepted at a clock edge ends with a single-cycle `done_o` pulse NPRIV + NUM_LPI + 1 cycles later. `valid_o`, `id_o` and `prio_o` change only in the cycle where `done_o` rises.
- R8: When no candidate exists, `valid_o` is 0 and `id_o` and `prio_o` are 0.
- R9: Reset clears all pending bits, `done_o` and `valid_o`.
- R10: A `start_i` pulse that arrives while a scan is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a scan when idle |
| irq_en_i | input | NPRIV | Private enable bits |
| irq_pend_i | input | NPRIV | Private pending bits |
| irq_act_i | input | NPRIV | Private active bits |
| irq_grp_i | input | NPRIV | Private group (0 or 1) |
| irq_prio_i | input | NPRIV*8 | Private priorities, byte p for interrupt p |
| grp_en_i | input | 2 | Group enables, bit g for group g |
| lpi_cmd_vld_i | input | 1 | Pending command strobe |
| lpi_cmd_set_i | input | 1 | 1 = set, 0 = clear |
| lpi_cmd_id_i | input | 16 | Target interrupt ID |
| lpi_idbits_i | input | 5 | ID-width value that sets the command limit |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_idx_i | input | log2(NUM_LPI) | Configuration index (ID − LPI_BASE) |
| cfg_data_i | input | 8 | Configuration byte: bit 0 enable, bits 7:2 priority |
| done_o | output | 1 | One-cycle pulse when the result updates |
| valid_o | output | 1 | A candidate was found |
| id_o | output | 16 | Winning interrupt ID |
| prio_o | output | 8 | Winning priority |

## Verification
Single private interrupts are tried with each of the four qualifying bits removed in turn, which shows that every gating term takes part. Pairs with equal and with distinct priorities separate the numeric compare from the ID tie-break. A message interrupt is placed against private interrupts with lower, equal and higher priority, and this exposes both the shift of its priority field and the tie-break across the two sources. Set and clear commands are issued at the window edges, at the run-time limit and just above it, then repeated, and each later scan shows whether the bit moved.

// File: rtl/hppi_pkg.sv
package hppi_pkg;
  localparam int ID_W   = 16;
  localparam int PRIO_W = 8;

  typedef struct packed {
    logic              vld;
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
  } cand_t;

  // true when a must replace b
  function automatic logic beats(input cand_t a, input cand_t b);
    if (!a.vld)                 return 1'b0;
    else if (!b.vld)            return 1'b1;
    else if (a.prio != b.prio)  return a.prio < b.prio;
    else                        return a.id < b.id;
  endfunction
endpackage

// File: rtl/hppi_lpi_store.sv
module hppi_lpi_store
  import hppi_pkg::*;
#(
  parameter int NUM_LPI  = 64,
  parameter int LPI_BASE = 8192,
  parameter int AW       = $clog2(NUM_LPI)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cmd_vld_i,
  input  logic                          cmd_set_i,
  input  logic [ID_W-1:0]               cmd_id_i,
  input  logic [4:0]                    idbits_i,
  input  logic                          cfg_we_i,
  input  logic [AW-1:0]                 cfg_waddr_i,
  input  logic [7:0]                    cfg_wdata_i,
  input  logic [AW-1:0]                 rd_addr_i,
  output logic [7:0]                    cfg_q_o,
  output logic                          pend_q_o,
  output logic [NUM_LPI/8-1:0][7:0]     pend_o
);
  localparam int NBYTE = NUM_LPI / 8;
  localparam logic [ID_W-1:0] BASE_V = ID_W'(LPI_BASE);
  localparam logic [ID_W-1:0] END_V  = ID_W'(LPI_BASE + NUM_LPI);

  logic [NBYTE-1:0][7:0] pend_q;
  logic [7:0]            cfg_mem [NUM_LPI];

  logic [32:0]     lim;
  logic [ID_W-1:0] off;
  logic            in_win, above, cmd_ok;

  always_comb begin
    lim    = 33'd1 << ({1'b0, idbits_i} + 6'd1);
    off    = cmd_id_i - BASE_V;
    in_win = (cmd_id_i >= BASE_V) && (cmd_id_i < END_V);
    above  = {{(33-ID_W){1'b0}}, cmd_id_i} > lim;
    cmd_ok = cmd_vld_i && in_win && !above;
  end

  // pending bitmap: byte off/8, bit id%8 (base is a multiple of 8)
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      pend_q_o <= 1'b0;
    end else begin
      if (cmd_ok) pend_q[off[AW-1:3]][cmd_id_i[2:0]] <= cmd_set_i;
      pend_q_o <= pend_q[rd_addr_i[AW-1:3]][rd_addr_i[2:0]];
    end
  end

  // configuration RAM, one write port and one registered read port
  always_ff @(posedge clk) begin
    if (cfg_we_i) cfg_mem[cfg_waddr_i] <= cfg_wdata_i;
    cfg_q_o <= cfg_mem[rd_addr_i];
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/hppi_scan_ctrl.sv
module hppi_scan_ctrl #(
  parameter int TOTAL = 96,
  parameter int IW    = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          clr_o,
  output logic [IW-1:0] idx_o,
  output logic          s2_vld_o,
  output logic [IW-1:0] s2_idx_o,
  output logic          last_o,
  output logic          busy_o
);
  logic run;

  assign clr_o  = start_i && !run && !s2_vld_o;
  assign busy_o = run || s2_vld_o;
  assign last_o = s2_vld_o && (s2_idx_o == IW'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      idx_o    <= '0;
      s2_vld_o <= 1'b0;
      s2_idx_o <= '0;
    end else begin
      s2_vld_o <= run;
      s2_idx_o <= idx_o;
      if (clr_o) begin
        run   <= 1'b1;
        idx_o <= '0;
      end else if (run) begin
        if (idx_o == IW'(TOTAL - 1)) run <= 1'b0;
        else                          idx_o <= idx_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hppi_best.sv
module hppi_best
  import hppi_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clr_i,
  input  logic  eval_i,
  input  cand_t cand_i,
  output cand_t best_next_o
);
  cand_t best_q;

  always_comb begin
    best_next_o = best_q;
    if (eval_i && beats(cand_i, best_q)) best_next_o = cand_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) best_q <= '0;
    else              best_q <= best_next_o;
  end
endmodule

// File: rtl/hppi_select.sv
module hppi_select
  import hppi_pkg::*;
#(
  parameter int NPRIV    = 32,
  parameter int NUM_LPI  = 64,
  parameter int LPI_BASE = 8192,
  parameter int AW       = $clog2(NUM_LPI)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [NPRIV-1:0]        irq_en_i,
  input  logic [NPRIV-1:0]        irq_pend_i,
  input  logic [NPRIV-1:0]        irq_act_i,
  input  logic [NPRIV-1:0]        irq_grp_i,
  input  logic [NPRIV*PRIO_W-1:0] irq_prio_i,
  input  logic [1:0]              grp_en_i,
  input  logic                    lpi_cmd_vld_i,
  input  logic                    lpi_cmd_set_i,
  input  logic [ID_W-1:0]         lpi_cmd_id_i,
  input  logic [4:0]              lpi_idbits_i,
  input  logic                    cfg_we_i,
  input  logic [AW-1:0]           cfg_idx_i,
  input  logic [7:0]              cfg_data_i,
  output logic                    done_o,
  output logic                    valid_o,
  output logic [ID_W-1:0]         id_o,
  output logic [PRIO_W-1:0]       prio_o
);
  localparam int TOTAL = NPRIV + NUM_LPI;
  localparam int IW    = $clog2(TOTAL);
  localparam int PW    = $clog2(NPRIV);

  logic          clr, s2_vld, last, busy;
  logic [IW-1:0] idx, s2_idx, lpi_rd, lpi_s2;
  logic [7:0]    cfg_q;
  logic          pend_bit;
  logic [NUM_LPI/8-1:0][7:0] pend_vec;
  cand_t         cand, best_next;

  hppi_scan_ctrl #(.TOTAL(TOTAL), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .clr_o(clr), .idx_o(idx),
    .s2_vld_o(s2_vld), .s2_idx_o(s2_idx), .last_o(last), .busy_o(busy)
  );

  assign lpi_rd = idx - IW'(NPRIV);
  assign lpi_s2 = s2_idx - IW'(NPRIV);

  hppi_lpi_store #(.NUM_LPI(NUM_LPI), .LPI_BASE(LPI_BASE), .AW(AW)) u_store (
    .clk(clk), .rst(rst),
    .cmd_vld_i(lpi_cmd_vld_i), .cmd_set_i(lpi_cmd_set_i), .cmd_id_i(lpi_cmd_id_i),
    .idbits_i(lpi_idbits_i),
    .cfg_we_i(cfg_we_i), .cfg_waddr_i(cfg_idx_i), .cfg_wdata_i(cfg_data_i),
    .rd_addr_i(lpi_rd[AW-1:0]), .cfg_q_o(cfg_q), .pend_q_o(pend_bit), .pend_o(pend_vec)
  );

  // candidate for the entry in stage two
  always_comb begin
    logic [PW-1:0] p;
    p = s2_idx[PW-1:0];
    if (s2_idx < IW'(NPRIV)) begin
      cand.vld  = irq_pend_i[p] && irq_en_i[p] && !irq_act_i[p] && grp_en_i[irq_grp_i[p]];
      cand.id   = ID_W'(p);
      cand.prio = irq_prio_i[p*PRIO_W +: PRIO_W];
    end else begin
      cand.vld  = pend_bit && cfg_q[0] && grp_en_i[1];
      cand.id   = ID_W'(LPI_BASE) + ID_W'(lpi_s2);
      cand.prio = {cfg_q[7:2], 2'b00};
    end
  end

  hppi_best u_best (
    .clk(clk), .rst(rst), .clr_i(clr), .eval_i(s2_vld),
    .cand_i(cand), .best_next_o(best_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o  <= 1'b0;
      valid_o <= 1'b0;
      id_o    <= '0;
      prio_o  <= '0;
    end else begin
      done_o <= last;
      if (last) begin
        valid_o <= best_next.vld;
        id_o    <= best_next.vld ? best_next.id   : '0;
        prio_o  <= best_next.vld ? best_next.prio : '0;
      end
    end
  end
endmodule

// File: rtl/hppi_select_chk.sv
module hppi_select_chk
  import hppi_pkg::*;
#(
  parameter int NPRIV    = 32,
  parameter int NUM_LPI  = 64,
  parameter int LPI_BASE = 8192
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      start_i,
  input logic                      busy,
  input logic                      lpi_cmd_vld_i,
  input logic [ID_W-1:0]           lpi_cmd_id_i,
  input logic [4:0]                lpi_idbits_i,
  input logic [NUM_LPI/8-1:0][7:0] pend,
  input logic                      done_o,
  input logic                      valid_o,
  input logic [ID_W-1:0]           id_o,
  input logic [PRIO_W-1:0]         prio_o
);
  localparam int TOTAL = NPRIV + NUM_LPI;

  logic [15:0] cnt;
  logic [32:0] lim;
  assign lim = 33'd1 << ({1'b0, lpi_idbits_i} + 6'd1);

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (start_i && !busy) cnt <= 16'd1;
    else if (done_o)           cnt <= '0;
    else if (cnt != 0)         cnt <= cnt + 16'd1;
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_timing_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cnt == 16'(TOTAL + 2)));
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(valid_o) && $stable(id_o) && $stable(prio_o)));
  p_none_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (id_o == '0 && prio_o == '0));
  p_lpi_prio_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_o && id_o >= ID_W'(LPI_BASE)) |-> (prio_o[1:0] == 2'b00));
  p_limit_r6: assert property (@(posedge clk) disable iff (rst)
    (lpi_cmd_vld_i && ({{(33-ID_W){1'b0}}, lpi_cmd_id_i} > lim)) |=> $stable(pend));
  p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy && !done_o) |=> !done_o || (cnt == 16'(TOTAL + 2)));
endmodule

bind hppi_select hppi_select_chk #(.NPRIV(NPRIV), .NUM_LPI(NUM_LPI), .LPI_BASE(LPI_BASE)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy(busy),
  .lpi_cmd_vld_i(lpi_cmd_vld_i), .lpi_cmd_id_i(lpi_cmd_id_i), .lpi_idbits_i(lpi_idbits_i),
  .pend(pend_vec), .done_o(done_o), .valid_o(valid_o), .id_o(id_o), .prio_o(prio_o)
);

// File: tb/hppi_select_tb_top.sv
`timescale 1ns/1ps
module hppi_select_tb_top;
  localparam int NPRIV = 32;
  localparam int NLPI  = 64;
  localparam int BASE  = 8192;
  localparam int TOTAL = NPRIV + NLPI;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              start_i = 0;
  logic [NPRIV-1:0]  en = '0, pd = '0, act = '0, grp = '0;
  logic [NPRIV*8-1:0] pri = '0;
  logic [1:0]        gen = 2'b11;
  logic              cvld = 0, cset = 0;
  logic [15:0]       cid = '0;
  logic [4:0]        idb = 5'd13;
  logic              cwe = 0;
  logic [5:0]        cidx = '0;
  logic [7:0]        cdat = '0;
  logic              done_o, valid_o;
  logic [15:0]       id_o;
  logic [7:0]        prio_o;

  hppi_select dut_i (
    .clk(clk), .rst(rst), .start_i(start_i),
    .irq_en_i(en), .irq_pend_i(pd), .irq_act_i(act), .irq_grp_i(grp), .irq_prio_i(pri),
    .grp_en_i(gen), .lpi_cmd_vld_i(cvld), .lpi_cmd_set_i(cset), .lpi_cmd_id_i(cid),
    .lpi_idbits_i(idb), .cfg_we_i(cwe), .cfg_idx_i(cidx), .cfg_data_i(cdat),
    .done_o(done_o), .valid_o(valid_o), .id_o(id_o), .prio_o(prio_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench-side model of the stored state
  logic [7:0] cfg_m [NLPI];
  logic       pend_m [NLPI];

  typedef struct { logic v; int id; int pr; int at; string tag; } exp_t;
  exp_t sbq[$];

  task automatic chk(input string tag, input int act_v, input int exp_v, input string what);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act_v, exp_v);
    end
  endtask

  // monitor: pops the scoreboard on every done pulse
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (sbq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.tag, int'(valid_o), int'(e.v), "valid");
        chk(e.tag, int'(id_o), e.id, "id");
        chk(e.tag, int'(prio_o), e.pr, "prio");
        chk("R7", cyc, e.at, "done cycle");
      end
    end
  end

  function automatic logic better(int pa, int ia, logic bv, int pb, int ib);
    if (!bv) return 1'b1;
    if (pa != pb) return pa < pb;
    return ia < ib;
  endfunction

  task automatic run_scan(input string tag);
    exp_t e;
    e.v = 0; e.id = 0; e.pr = 0; e.tag = tag;
    for (int p = 0; p < NPRIV; p++)
      if (pd[p] && en[p] && !act[p] && gen[grp[p]] && better(int'(pri[p*8 +: 8]), p, e.v, e.pr, e.id)) begin
        e.v = 1; e.id = p; e.pr = int'(pri[p*8 +: 8]);
      end
    for (int j = 0; j < NLPI; j++)
      if (pend_m[j] && cfg_m[j][0] && gen[1] && better(int'(cfg_m[j][7:2]) * 4, BASE + j, e.v, e.pr, e.id)) begin
        e.v = 1; e.id = BASE + j; e.pr = int'(cfg_m[j][7:2]) * 4;
      end
    @(negedge clk);
    e.at = cyc + TOTAL + 2;
    sbq.push_back(e);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    while (sbq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg_wr(input int j, input logic [7:0] d);
    @(negedge clk);
    cwe = 1; cidx = 6'(j); cdat = d;
    cfg_m[j] = d;
    @(negedge clk);
    cwe = 0;
  endtask

  task automatic lpi_cmd(input logic s, input int id);
    longint lim;
    lim = longint'(1) << (int'(idb) + 1);
    @(negedge clk);
    cvld = 1; cset = s; cid = 16'(id);
    if (id >= BASE && id < BASE + NLPI && longint'(id) <= lim) pend_m[id - BASE] = s;
    @(negedge clk);
    cvld = 0;
  endtask

  task automatic set_priv(input int p, input logic e_, input logic pn, input logic ac,
                          input logic g, input logic [7:0] pr);
    en[p] = e_; pd[p] = pn; act[p] = ac; grp[p] = g; pri[p*8 +: 8] = pr;
  endtask

  task automatic clear_priv();
    en = '0; pd = '0; act = '0; grp = '0; pri = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int j = 0; j < NLPI; j++) begin cfg_m[j] = 8'h00; pend_m[j] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    for (int j = 0; j < NLPI; j++) cfg_wr(j, 8'h00);
    @(negedge clk);
    chk("R9", int'(done_o), 0, "done after reset");
    chk("R9", int'(valid_o), 0, "valid after reset");

    run_scan("R8");                                     // nothing pending

    set_priv(5, 1, 1, 0, 0, 8'h40);
    run_scan("R1");                                     // single private
    act[5] = 1;  run_scan("R1");  act[5] = 0;           // active blocks
    en[5] = 0;   run_scan("R1");  en[5] = 1;            // disabled blocks
    gen = 2'b10; run_scan("R1");  gen = 2'b11;          // group 0 off
    grp[5] = 1;  gen = 2'b01; run_scan("R1"); gen = 2'b11; grp[5] = 0;

    clear_priv();
    set_priv(9, 1, 1, 0, 0, 8'h30);
    set_priv(3, 1, 1, 0, 1, 8'h30);
    run_scan("R2");                                     // tie -> id 3
    set_priv(20, 1, 1, 0, 0, 8'h10);
    run_scan("R2");                                     // lower prio -> id 20

    clear_priv();
    set_priv(7, 1, 1, 0, 0, 8'h40);
    cfg_wr(8, 8'h15);                                   // prio field 5 -> 0x14
    lpi_cmd(1, BASE + 8);
    run_scan("R4");                                     // LPI wins at 0x14
    cfg_wr(8, 8'h14);  run_scan("R3");                  // enable bit clear
    cfg_wr(8, 8'h15);  gen = 2'b01; run_scan("R3"); gen = 2'b11;
    cfg_wr(8, 8'h41);                                   // prio 0x40 tie with id 7
    run_scan("R2");
    cfg_wr(8, 8'hFD);  run_scan("R4");                  // prio 0xFC, private wins

    cfg_wr(8, 8'h09);                                   // prio 8
    lpi_cmd(1, BASE + 8);  run_scan("R5");              // repeat set
    lpi_cmd(0, BASE + 8);  run_scan("R5");              // clear
    lpi_cmd(0, BASE + 8);  run_scan("R5");              // repeat clear

    cfg_wr(0, 8'h05);  cfg_wr(1, 8'h05);  cfg_wr(63, 8'h01);
    idb = 5'd12;                                        // limit 8192
    lpi_cmd(1, BASE + 1);  run_scan("R6");              // above limit, ignored
    lpi_cmd(1, BASE);      run_scan("R6");              // equal to limit, taken
    lpi_cmd(0, BASE);
    idb = 5'd13;
    lpi_cmd(1, BASE + NLPI);  run_scan("R6");           // outside window
    lpi_cmd(1, BASE - 1);     run_scan("R6");
    lpi_cmd(1, BASE + 63);    run_scan("R6");           // last slot accepted

    // R10: second start during a scan
    clear_priv();
    set_priv(2, 1, 1, 0, 0, 8'h00);
    begin
      exp_t e;
      e.v = 1; e.id = 2; e.pr = 0; e.tag = "R10";
      @(negedge clk);
      e.at = cyc + TOTAL + 2;
      sbq.push_back(e);
      start_i = 1; @(negedge clk); start_i = 0;
      repeat (10) @(negedge clk);
      start_i = 1; @(negedge clk); start_i = 0;
      while (sbq.size() != 0) @(negedge clk);
      repeat (TOTAL + 10) @(negedge clk);
    end

    // R9: reset wipes pending state
    cfg_wr(4, 8'h01);
    lpi_cmd(1, BASE + 4);
    clear_priv();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    for (int j = 0; j < NLPI; j++) pend_m[j] = 0;
    run_scan("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule